// File: doc/BRIEF.md
# Segment-to-Page Memory Mapper with Boot Overlay

This block sits between a segmented 16-bit processor and a memory system made of a 1 MB flash and a 1 MB RAM. Each memory is split into sixteen 64 KB pages. The processor supplies a 7-bit segment number and a 16-bit offset. The mapper turns the segment into a 4-bit page number and chooses which memory answers. Programs can keep their instructions and their data in separate segments: one segment resolves to a different RAM page for instruction fetches than for data or stack accesses.

A boot flag is set by reset. While the flag is set, segment 0 is redirected to the top flash page, so the processor reads its reset vector from non-volatile storage. The flag clears the first time an address with offset bit 3 high is strobed. After that, segment 0 reaches RAM. The mapper also derives byte-lane enables for the two byte-wide chips. It flags any segment that has no page with a one-cycle trap pulse.

The mapping inputs are captured on a one-cycle address strobe and held until the next strobe. The chip selects follow the live memory-request qualifier, so they stay inactive during I/O and internal cycles.

Top module: `seg_page_mapper`

## Requirements
- R1: While reset is high, and after it until the first strobe, both chip selects, both lane enables and the trap are low, and `phys_addr` is 0. Reset also sets the boot flag.
- R2: A strobe captures the inputs. From the next cycle, `phys_addr[15:0]` equals the strobed offset, and `phys_addr[19:16]` equals the resolved page.
- R3: While the boot flag is set, segment 0 resolves to flash page 15 (`flash_cs` high, `ram_cs` low).
- R4: A strobe whose offset bit 3 is 1 clears the boot flag. That access and all later ones to segment 0 resolve to RAM page 0. Only reset sets the flag again.
- R5: Segment 60 resolves to flash page 15, whatever the state of the boot flag.
- R6: Segment 1 and segment 19 resolve to RAM page 1, and segment 3 resolves to RAM page 3, for every access type.
- R7: Segment 11 resolves to RAM page 1 when `ifetch` is 1, and to RAM page 9 when `ifetch` is 0.
- R8: The lane enables depend on `byte_acc` and offset bit 0:
  - A word access (`byte_acc`=0) raises both `lane_hi` and `lane_lo`.
  - A byte access raises only `lane_hi` when offset bit 0 is 0.
  - A byte access raises only `lane_lo` when offset bit 0 is 1.
  - Both lane enables are low whenever no chip select is active.
- R9: A chip select is high only while `mem_req` is high and the held access resolved to that memory. The two chip selects are never high together.
- R10: A strobe with `mem_req` high to a segment outside the map raises `seg_trap` for exactly the next cycle. That access keeps both chip selects and both lane enables low.
- R11: Input changes without a strobe leave `phys_addr`, the resolved target and the lane enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; sets the boot flag |
| addr_stb | input | 1 | One-cycle pulse that captures the segment, offset and access type |
| seg_in | input | 7 | Segment number |
| off_in | input | 16 | Offset within the segment |
| ifetch | input | 1 | 1 = instruction fetch, 0 = data or stack access |
| byte_acc | input | 1 | 1 = byte access, 0 = word access |
| mem_req | input | 1 | Memory-request qualifier that gates the chip selects |
| phys_addr | output | 20 | Page number in bits 19:16, offset in bits 15:0 |
| flash_cs | output | 1 | Flash select, active high |
| ram_cs | output | 1 | RAM select, active high |
| lane_hi | output | 1 | High byte chip enable (data bits 15:8) |
| lane_lo | output | 1 | Low byte chip enable (data bits 7:0) |
| seg_trap | output | 1 | One-cycle pulse for an access to an unmapped segment |

## Verification
A boot flag stuck high would leave segment 0 selecting flash after the vector fetch. A flag that clears too early would send the vector fetch to RAM. Either fault shows on the chip selects and the page bits in the cycle right after the affected strobe. A corrupted held register shows as a change of `phys_addr` or the lane enables on a cycle with no strobe. A wrong split decode shows as page 1 and page 9 swapped on the first segment-11 access of each type. The bench compares every output against its model on every clock, so each of these faults appears within one cycle of its cause.

// File: rtl/smap_pkg.sv
package smap_pkg;

    localparam int SEG_W  = 7;
    localparam int OFF_W  = 16;
    localparam int PAGE_W = 4;
    localparam int PA_W   = OFF_W + PAGE_W;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_RAM   = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [PAGE_W-1:0] page;
    } route_t;

    typedef struct packed {
        route_t           route;
        logic [OFF_W-1:0] off;
        logic             hi_en;
        logic             lo_en;
    } hold_t;

    function automatic route_t mk_route(tgt_e t, logic [PAGE_W-1:0] p);
        route_t r;
        r.tgt  = t;
        r.page = p;
        return r;
    endfunction

endpackage

// File: rtl/smap_boot_flag.sv
module smap_boot_flag (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic clr_bit,
    output logic boot_now
);
    logic boot_q;
    logic clr_hit;

    assign clr_hit  = stb & clr_bit;
    // The access that carries the clearing bit already sees the flag cleared.
    assign boot_now = boot_q & ~clr_hit;

    always_ff @(posedge clk) begin
        if (rst)
            boot_q <= 1'b1;
        else if (clr_hit)
            boot_q <= 1'b0;
    end
endmodule

// File: rtl/smap_seg_decode.sv
module smap_seg_decode
    import smap_pkg::*;
#(
    parameter int SEG_LOW   = 0,
    parameter int SEG_USER  = 1,
    parameter int SEG_SYS   = 3,
    parameter int SEG_SPLIT = 11,
    parameter int SEG_IASD  = 19,
    parameter int SEG_ROM   = 60,
    parameter int PG_LOW    = 0,
    parameter int PG_USER   = 1,
    parameter int PG_SYS    = 3,
    parameter int PG_DATA   = 9,
    parameter int PG_ROM    = 15
) (
    input  logic [SEG_W-1:0] seg,
    input  logic             ifetch,
    input  logic             boot,
    output route_t           route
);
    localparam logic [PAGE_W-1:0] P_LOW  = PAGE_W'(PG_LOW);
    localparam logic [PAGE_W-1:0] P_USER = PAGE_W'(PG_USER);
    localparam logic [PAGE_W-1:0] P_SYS  = PAGE_W'(PG_SYS);
    localparam logic [PAGE_W-1:0] P_DATA = PAGE_W'(PG_DATA);
    localparam logic [PAGE_W-1:0] P_ROM  = PAGE_W'(PG_ROM);

    always_comb begin
        route = mk_route(TGT_NONE, '0);
        if (seg == SEG_W'(SEG_ROM))
            route = mk_route(TGT_FLASH, P_ROM);
        else if (seg == SEG_W'(SEG_LOW))
            route = boot ? mk_route(TGT_FLASH, P_ROM) : mk_route(TGT_RAM, P_LOW);
        else if (seg == SEG_W'(SEG_USER))
            route = mk_route(TGT_RAM, P_USER);
        else if (seg == SEG_W'(SEG_SYS))
            route = mk_route(TGT_RAM, P_SYS);
        else if (seg == SEG_W'(SEG_SPLIT))
            route = mk_route(TGT_RAM, ifetch ? P_USER : P_DATA);
        else if (seg == SEG_W'(SEG_IASD))
            route = mk_route(TGT_RAM, P_USER);
    end
endmodule

// File: rtl/smap_lane_enable.sv
module smap_lane_enable #(
    parameter bit BIG_END = 1'b1
) (
    input  logic byte_acc,
    input  logic a0,
    output logic hi_en,
    output logic lo_en
);
    generate
        if (BIG_END) begin : g_big
            assign hi_en = ~byte_acc | ~a0;
            assign lo_en = ~byte_acc |  a0;
        end else begin : g_little
            assign hi_en = ~byte_acc |  a0;
            assign lo_en = ~byte_acc | ~a0;
        end
    endgenerate
endmodule

// File: rtl/seg_page_mapper.sv
module seg_page_mapper
    import smap_pkg::*;
#(
    parameter int SEG_LOW   = 0,
    parameter int SEG_USER  = 1,
    parameter int SEG_SYS   = 3,
    parameter int SEG_SPLIT = 11,
    parameter int SEG_IASD  = 19,
    parameter int SEG_ROM   = 60,
    parameter int BOOT_BIT  = 3,
    parameter bit BIG_END   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_stb,
    input  logic [SEG_W-1:0] seg_in,
    input  logic [OFF_W-1:0] off_in,
    input  logic             ifetch,
    input  logic             byte_acc,
    input  logic             mem_req,
    output logic [PA_W-1:0]  phys_addr,
    output logic             flash_cs,
    output logic             ram_cs,
    output logic             lane_hi,
    output logic             lane_lo,
    output logic             seg_trap
);
    logic   boot_now;
    route_t route_d;
    logic   hi_d, lo_d;
    hold_t  hold_q;
    logic   trap_q;
    logic   sel_ok;

    smap_boot_flag u_boot (
        .clk      (clk),
        .rst      (rst),
        .stb      (addr_stb),
        .clr_bit  (off_in[BOOT_BIT]),
        .boot_now (boot_now)
    );

    smap_seg_decode #(
        .SEG_LOW  (SEG_LOW),
        .SEG_USER (SEG_USER),
        .SEG_SYS  (SEG_SYS),
        .SEG_SPLIT(SEG_SPLIT),
        .SEG_IASD (SEG_IASD),
        .SEG_ROM  (SEG_ROM)
    ) u_dec (
        .seg    (seg_in),
        .ifetch (ifetch),
        .boot   (boot_now),
        .route  (route_d)
    );

    smap_lane_enable #(.BIG_END(BIG_END)) u_lane (
        .byte_acc (byte_acc),
        .a0       (off_in[0]),
        .hi_en    (hi_d),
        .lo_en    (lo_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '{route: mk_route(TGT_NONE, '0), off: '0, hi_en: 1'b0, lo_en: 1'b0};
            trap_q <= 1'b0;
        end else begin
            trap_q <= addr_stb & mem_req & (route_d.tgt == TGT_NONE);
            if (addr_stb)
                hold_q <= '{route: route_d, off: off_in, hi_en: hi_d, lo_en: lo_d};
        end
    end

    assign sel_ok    = mem_req & (hold_q.route.tgt != TGT_NONE);
    assign flash_cs  = mem_req & (hold_q.route.tgt == TGT_FLASH);
    assign ram_cs    = mem_req & (hold_q.route.tgt == TGT_RAM);
    assign lane_hi   = sel_ok & hold_q.hi_en;
    assign lane_lo   = sel_ok & hold_q.lo_en;
    assign phys_addr = {hold_q.route.page, hold_q.off};
    assign seg_trap  = trap_q;
endmodule

// File: rtl/seg_page_mapper_chk.sv
module seg_page_mapper_chk
    import smap_pkg::*;
#(
    parameter int SEG_ROM = 60
) (
    input logic             clk,
    input logic             rst,
    input logic             addr_stb,
    input logic [SEG_W-1:0] seg_in,
    input logic             mem_req,
    input logic [PA_W-1:0]  phys_addr,
    input logic             flash_cs,
    input logic             ram_cs,
    input logic             lane_hi,
    input logic             lane_lo,
    input logic             seg_trap
);
    p_cs_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(flash_cs && ram_cs));

    p_no_req_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> (!flash_cs && !ram_cs));

    p_lane_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !(flash_cs || ram_cs) |-> (!lane_hi && !lane_lo));

    p_trap_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        seg_trap |-> (!flash_cs && !ram_cs && $past(addr_stb)));

    p_held_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(addr_stb)) |-> $stable(phys_addr));

    p_rom_seg_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(addr_stb) && $past(seg_in) == SEG_W'(SEG_ROM))
            |-> phys_addr[PA_W-1 -: PAGE_W] == {PAGE_W{1'b1}});
endmodule

bind seg_page_mapper seg_page_mapper_chk u_chk (.*);

// File: tb/sim_seg_page_mapper.sv
module sim_seg_page_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        addr_stb;
    logic [6:0]  seg_in;
    logic [15:0] off_in;
    logic        ifetch, byte_acc, mem_req;
    logic [19:0] phys_addr;
    logic        flash_cs, ram_cs, lane_hi, lane_lo, seg_trap;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int   m_tgt;   // 0 none, 1 flash, 2 ram
    int   m_page;
    int   m_off;
    bit   m_hi, m_lo, m_boot, m_trap;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_page_mapper u0 (
        .clk(clk), .rst(rst), .addr_stb(addr_stb), .seg_in(seg_in),
        .off_in(off_in), .ifetch(ifetch), .byte_acc(byte_acc),
        .mem_req(mem_req), .phys_addr(phys_addr), .flash_cs(flash_cs),
        .ram_cs(ram_cs), .lane_hi(lane_hi), .lane_lo(lane_lo),
        .seg_trap(seg_trap)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        bit b;
        if (rst) begin
            m_boot = 1; m_tgt = 0; m_page = 0; m_off = 0;
            m_hi = 0; m_lo = 0; m_trap = 0;
        end else begin
            m_trap = 0;
            if (addr_stb) begin
                b = m_boot && !off_in[3];
                case (seg_in)
                    7'd60: begin m_tgt = 1; m_page = 15; end
                    7'd0:  begin m_tgt = b ? 1 : 2; m_page = b ? 15 : 0; end
                    7'd1, 7'd19: begin m_tgt = 2; m_page = 1; end
                    7'd3:  begin m_tgt = 2; m_page = 3; end
                    7'd11: begin m_tgt = 2; m_page = ifetch ? 1 : 9; end
                    default: begin m_tgt = 0; m_page = 0; end
                endcase
                m_off = off_in;
                m_hi  = !byte_acc || !off_in[0];
                m_lo  = !byte_acc ||  off_in[0];
                m_trap = mem_req && m_tgt == 0;
                if (off_in[3]) m_boot = 0;
            end
        end
    endtask

    // one clock: drive at negedge, model after posedge, compare at next negedge
    task automatic step(bit s, int sg, int of, bit f, bit b, bit m, string tag);
        bit sel;
        addr_stb = s; seg_in = 7'(sg); off_in = 16'(of);
        ifetch = f; byte_acc = b; mem_req = m;
        @(posedge clk);
        model_update();
        @(negedge clk);
        sel = mem_req && m_tgt != 0;
        chk(tag, "phys_addr", int'(phys_addr), (m_page << 16) | m_off);
        chk(tag, "flash_cs", int'(flash_cs), int'(mem_req && m_tgt == 1));
        chk(tag, "ram_cs",   int'(ram_cs),   int'(mem_req && m_tgt == 2));
        chk(tag, "lane_hi",  int'(lane_hi),  int'(sel && m_hi));
        chk(tag, "lane_lo",  int'(lane_lo),  int'(sel && m_lo));
        chk(tag, "seg_trap", int'(seg_trap), int'(m_trap));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        @(negedge clk);
        step(0, 0, 0, 0, 0, 1, "R1");           // reset state
        step(1, 0, 2, 0, 0, 1, "R1");           // strobe ignored under reset
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 1, "R1");           // quiet after reset
        // R3: vector fetch from flash page 15
        step(1, 0, 2, 0, 0, 1, "R3");
        step(1, 0, 4, 0, 0, 1, "R3");
        step(1, 0, 6, 0, 1, 1, "R8");           // byte, even: high lane
        step(1, 0, 7, 0, 1, 1, "R8");           // byte, odd: low lane
        // R9: qualifier low blocks selects, held access returns when raised
        step(1, 0, 2, 0, 0, 0, "R9");
        step(0, 0, 2, 0, 0, 0, "R9");
        step(0, 0, 2, 0, 0, 1, "R9");
        // R11: inputs wiggle with no strobe
        step(0, 11, 16'hABCD, 1, 1, 1, "R11");
        step(0, 77, 16'h1239, 0, 0, 1, "R11");
        // R5 + R4: jump to segment 60 with bit 3 high clears boot
        step(1, 60, 16'h000C, 1, 0, 1, "R5");
        step(1, 0, 16'h0000, 0, 0, 1, "R4");
        step(1, 0, 16'h0002, 1, 0, 1, "R4");
        step(1, 60, 16'h0200, 0, 0, 1, "R5");
        // R6 / R7
        step(1, 1, 16'h1234, 1, 0, 1, "R6");
        step(1, 3, 16'h8000, 0, 0, 1, "R6");
        step(1, 19, 16'h4444, 0, 0, 1, "R6");
        step(1, 19, 16'h4445, 1, 1, 1, "R6");
        step(1, 11, 16'h0100, 1, 0, 1, "R7");
        step(1, 11, 16'h0100, 0, 0, 1, "R7");
        step(1, 11, 16'hFFFF, 0, 1, 1, "R7");
        // R10: unmapped segments, one-cycle trap
        step(1, 5, 16'h0010, 0, 0, 1, "R10");
        step(0, 5, 16'h0010, 0, 0, 1, "R10");
        step(1, 127, 16'h0001, 1, 1, 1, "R10");
        step(1, 2, 16'h0001, 1, 1, 1, "R10");
        step(0, 0, 0, 0, 0, 1, "R10");
        step(1, 61, 16'h0000, 0, 0, 0, "R10");  // no request: no trap
        // R4: boot flag cleared on the very access that carries bit 3
        rst = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R1");
        rst = 1'b0;
        step(1, 0, 16'h0008, 0, 0, 1, "R4");
        step(1, 0, 16'h0002, 0, 0, 1, "R4");
        step(1, 60, 16'h0002, 1, 0, 1, "R5");
        for (int i = 0; i < 8; i++)
            step(1, (i % 2) ? 11 : 3, i * 16'h1111, i[1], i[2], 1, "R2");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule